// File: doc/BRIEF.md
# Transparent Cursor Overlay

This block paints a 32x32 cursor with 4 bits per pixel onto one scanline of packed pixel nibbles. It works on the line buffer before that buffer reaches the pixel-to-TMDS encoder. The cursor position and the transparency mode are latched at frame start. At each line start the block compares the line number with the latched cursor Y. If the line falls inside the cursor, the block reads the matching 128-bit cursor row from an external image memory. It then aligns that row to the cursor X position. Each affected 32-bit line-buffer word goes through a read-modify-write, and only opaque cursor pixels are merged into it.

Pixel `p` of the line sits in word `p/8`, bits `[4*(p%8)+3 : 4*(p%8)]`, so the leftmost pixel is the low nibble. When X is not a multiple of 8, one cursor row spreads over five words. Words past the end of the 640-pixel line are never touched. A one-cycle `done_o` pulse tells the line sequencer that the line can be handed to the encoder.

Top module: `cursor_ovl`

## Requirements
- R1: In normal mode (`alt_mode_i`=0 at frame start), a cursor pixel with a non-zero value replaces the underlying line pixel.
- R2: In normal mode, a cursor pixel of value 0000 leaves the underlying pixel unchanged.
- R3: In alternate mode (`alt_mode_i`=1 at frame start), a cursor pixel of value 0000 is opaque and writes 0000. A non-zero cursor pixel leaves the underlying pixel unchanged.
- R4: Each written word is first read at the same address in the cycle before. When X is a multiple of 8, exactly 4 words are rewritten. Otherwise exactly 5 words are rewritten, starting at word `X/8`.
- R5: Line-buffer words at index 80 or above are never read or written, so cursor pixels past pixel 639 are dropped. Cursor pixel `j` of a row is taken from image bits `[4j+3:4j]` and lands on line pixel `X+j`.
- R6: A line is covered when `(line_y_i - Y) mod 1024` is in 0..31. That difference is the cursor row index, driven on `img_row_o` with `img_rd_o` for one cycle, and the data arrives on `img_data_i` one cycle later. Lines that are not covered cause no line-buffer access.
- R7: `cur_x_i`, `cur_y_i` and `alt_mode_i` take effect only in a cycle with `frame_start_i` high. Changes at other times do not affect later lines.
- R8: `done_o` is high for exactly one cycle per accepted line start. It comes after the last write-back, or directly after the line start when nothing is written.
- R9: While reset is held, `img_rd_o`, `lb_rd_o`, `lb_wr_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Latches cursor position and mode |
| cur_x_i | input | 10 | Cursor left pixel column |
| cur_y_i | input | 10 | Cursor top line |
| alt_mode_i | input | 1 | 1: value 0000 is the opaque value |
| line_start_i | input | 1 | Start overlay for the line in `line_y_i` (accepted when idle) |
| line_y_i | input | 10 | Current scanline number |
| img_rd_o | output | 1 | Cursor image row read strobe |
| img_row_o | output | 5 | Cursor row index |
| img_data_i | input | 128 | Cursor row, 32 nibbles, one cycle after read |
| lb_rd_o | output | 1 | Line-buffer read strobe |
| lb_wr_o | output | 1 | Line-buffer write strobe |
| lb_addr_o | output | 7 | Line-buffer word address |
| lb_wdata_o | output | 32 | Merged word to write back |
| lb_rdata_i | input | 32 | Word read, one cycle after read |
| done_o | output | 1 | Line finished pulse |

## Verification
If the sampled slot counter or word base holds a wrong value, pixels land in the wrong word or at the wrong nibble offset. This shows up in the line-buffer contents as soon as the line's `done_o` pulse has gone by. A wrong last-slot or clipping decision shows up in the same line as a write count different from 4, 5, or the clipped count, or as a write at index 80 or above. A wrong opacity decision shows up as pixels corrupted exactly where the cursor image holds 0000. A stale or missing frame latch shows up on the first covered line after the frame start.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_IMG,
    S_LOAD,
    S_RD,
    S_WR,
    S_DONE
  } ovl_st_e;
endpackage

// File: rtl/cursor_ovl_pos.sv
module cursor_ovl_pos #(
  parameter int unsigned COORD_W = 10,
  parameter int unsigned CUR_DIM = 32,
  localparam int unsigned RSEL_W = $clog2(CUR_DIM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic               alt_mode_i,
  input  logic [COORD_W-1:0] line_y_i,
  output logic [COORD_W-1:0] cx_o,
  output logic               alt_o,
  output logic               hit_o,
  output logic [RSEL_W-1:0]  row_o
);
  logic [COORD_W-1:0] cx_q, cy_q, dy;
  logic               alt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cx_q  <= '0;
      cy_q  <= '0;
      alt_q <= 1'b0;
    end else if (frame_start_i) begin
      cx_q  <= cur_x_i;
      cy_q  <= cur_y_i;
      alt_q <= alt_mode_i;
    end
  end

  // modular distance, so a cursor above line 0 wraps
  assign dy    = line_y_i - cy_q;
  assign hit_o = dy < COORD_W'(CUR_DIM);
  assign row_o = dy[RSEL_W-1:0];
  assign cx_o  = cx_q;
  assign alt_o = alt_q;
endmodule

// File: rtl/cursor_ovl_align.sv
module cursor_ovl_align #(
  parameter int unsigned PIX_W    = 4,
  parameter int unsigned CUR_DIM  = 32,
  parameter int unsigned WORD_PIX = 8,
  localparam int unsigned WORD_W = PIX_W * WORD_PIX,
  localparam int unsigned ROW_W  = PIX_W * CUR_DIM,
  localparam int unsigned SPAN   = CUR_DIM / WORD_PIX + 1,
  localparam int unsigned OFF_W  = $clog2(WORD_PIX),
  localparam int unsigned SLOT_W = $clog2(SPAN)
) (
  input  logic [ROW_W-1:0]    row_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [SLOT_W-1:0]   slot_i,
  output logic [WORD_W-1:0]   pix_o,
  output logic [WORD_PIX-1:0] vld_o
);
  localparam int unsigned EXT_W = SPAN * WORD_W;
  localparam int unsigned VM_W  = SPAN * WORD_PIX;

  logic [EXT_W-1:0] ext;
  logic [VM_W-1:0]  vm;

  always_comb begin
    ext   = EXT_W'(row_i) << (int'(off_i) * PIX_W);
    vm    = VM_W'({CUR_DIM{1'b1}}) << off_i;
    pix_o = ext[int'(slot_i)*WORD_W +: WORD_W];
    vld_o = vm[int'(slot_i)*WORD_PIX +: WORD_PIX];
  end
endmodule

// File: rtl/cursor_ovl_merge.sv
module cursor_ovl_merge #(
  parameter int unsigned PIX_W    = 4,
  parameter int unsigned WORD_PIX = 8,
  localparam int unsigned WORD_W = PIX_W * WORD_PIX
) (
  input  logic [WORD_W-1:0]   base_i,
  input  logic [WORD_W-1:0]   pix_i,
  input  logic [WORD_PIX-1:0] vld_i,
  input  logic                alt_i,
  output logic [WORD_W-1:0]   out_o
);
  for (genvar g = 0; g < WORD_PIX; g++) begin : g_nib
    logic [PIX_W-1:0] c;
    logic             zero, opq;
    assign c    = pix_i[g*PIX_W +: PIX_W];
    assign zero = (c == '0);
    assign opq  = vld_i[g] & (alt_i ? zero : !zero);
    assign out_o[g*PIX_W +: PIX_W] = opq ? c : base_i[g*PIX_W +: PIX_W];
  end
endmodule

// File: rtl/cursor_ovl.sv
module cursor_ovl
  import cursor_ovl_pkg::*;
#(
  parameter int unsigned COORD_W  = 10,
  parameter int unsigned LINE_PIX = 640,
  parameter int unsigned CUR_DIM  = 32,
  parameter int unsigned PIX_W    = 4,
  parameter int unsigned WORD_PIX = 8,
  localparam int unsigned WORD_W     = PIX_W * WORD_PIX,
  localparam int unsigned ROW_W      = PIX_W * CUR_DIM,
  localparam int unsigned LINE_WORDS = LINE_PIX / WORD_PIX,
  localparam int unsigned ADDR_W     = $clog2(LINE_WORDS),
  localparam int unsigned RSEL_W     = $clog2(CUR_DIM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic [COORD_W-1:0] cur_x_i,
  input  logic [COORD_W-1:0] cur_y_i,
  input  logic               alt_mode_i,
  input  logic               line_start_i,
  input  logic [COORD_W-1:0] line_y_i,
  output logic               img_rd_o,
  output logic [RSEL_W-1:0]  img_row_o,
  input  logic [ROW_W-1:0]   img_data_i,
  output logic               lb_rd_o,
  output logic               lb_wr_o,
  output logic [ADDR_W-1:0]  lb_addr_o,
  output logic [WORD_W-1:0]  lb_wdata_o,
  input  logic [WORD_W-1:0]  lb_rdata_i,
  output logic               done_o
);
  localparam int unsigned SPAN   = CUR_DIM / WORD_PIX + 1;
  localparam int unsigned OFF_W  = $clog2(WORD_PIX);
  localparam int unsigned SLOT_W = $clog2(SPAN);
  localparam int unsigned WIDX_W = COORD_W - OFF_W + 1;

  logic [COORD_W-1:0] cx;
  logic               alt_s, hit;
  logic [RSEL_W-1:0]  row_sel;

  cursor_ovl_pos #(.COORD_W(COORD_W), .CUR_DIM(CUR_DIM)) u_pos (
    .clk_i, .rst_ni, .frame_start_i, .cur_x_i, .cur_y_i, .alt_mode_i, .line_y_i,
    .cx_o(cx), .alt_o(alt_s), .hit_o(hit), .row_o(row_sel)
  );

  ovl_st_e           st_q, st_d;
  logic [RSEL_W-1:0] rsel_q;
  logic [WIDX_W-1:0] wbase_q, widx, nidx;
  logic [OFF_W-1:0]  off_q;
  logic              alt_q;
  logic [ROW_W-1:0]  row_q;
  logic [SLOT_W-1:0] slot_q, last_slot;
  logic              wr_last;

  assign widx      = wbase_q + WIDX_W'(slot_q);
  assign nidx      = widx + WIDX_W'(1);
  assign last_slot = (off_q == '0) ? SLOT_W'(SPAN - 2) : SLOT_W'(SPAN - 1);
  // stop at the row's last slot or at the right edge of the line
  assign wr_last   = (slot_q == last_slot) || (nidx >= WIDX_W'(LINE_WORDS));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (line_start_i) st_d = hit ? S_IMG : S_DONE;
      S_IMG:  st_d = S_LOAD;
      S_LOAD: st_d = (wbase_q < WIDX_W'(LINE_WORDS)) ? S_RD : S_DONE;
      S_RD:   st_d = S_WR;
      S_WR:   st_d = wr_last ? S_DONE : S_RD;
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      rsel_q  <= '0;
      wbase_q <= '0;
      off_q   <= '0;
      alt_q   <= 1'b0;
      row_q   <= '0;
      slot_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && line_start_i && hit) begin
        rsel_q  <= row_sel;
        wbase_q <= {1'b0, cx[COORD_W-1:OFF_W]};
        off_q   <= cx[OFF_W-1:0];
        alt_q   <= alt_s;
      end
      if (st_q == S_LOAD) begin
        row_q  <= img_data_i;
        slot_q <= '0;
      end
      if (st_q == S_WR && !wr_last) slot_q <= slot_q + SLOT_W'(1);
    end
  end

  logic [WORD_W-1:0]   cpix;
  logic [WORD_PIX-1:0] cvld;

  cursor_ovl_align #(.PIX_W(PIX_W), .CUR_DIM(CUR_DIM), .WORD_PIX(WORD_PIX)) u_align (
    .row_i(row_q), .off_i(off_q), .slot_i(slot_q), .pix_o(cpix), .vld_o(cvld)
  );

  cursor_ovl_merge #(.PIX_W(PIX_W), .WORD_PIX(WORD_PIX)) u_merge (
    .base_i(lb_rdata_i), .pix_i(cpix), .vld_i(cvld), .alt_i(alt_q), .out_o(lb_wdata_o)
  );

  assign img_rd_o  = (st_q == S_IMG);
  assign img_row_o = rsel_q;
  assign lb_rd_o   = (st_q == S_RD);
  assign lb_wr_o   = (st_q == S_WR);
  assign lb_addr_o = widx[ADDR_W-1:0];
  assign done_o    = (st_q == S_DONE);
endmodule

// File: rtl/cursor_ovl_chk.sv
module cursor_ovl_chk #(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned LINE_WORDS = 80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              img_rd_o,
  input logic              lb_rd_o,
  input logic              lb_wr_o,
  input logic [ADDR_W-1:0] lb_addr_o,
  input logic              done_o
);
  // R4: write-back follows a read of the same word
  a_r4_wr_after_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_wr_o |-> $past(lb_rd_o) && (lb_addr_o == $past(lb_addr_o)));

  // R5: no access beyond the line
  a_r5_addr_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_rd_o || lb_wr_o) |-> (lb_addr_o < ADDR_W'(LINE_WORDS)));

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8: done is not raised alongside a memory access
  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !lb_rd_o && !lb_wr_o && !img_rd_o);

  // R6: one image read per line
  a_r6_img_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    img_rd_o |=> !img_rd_o && !lb_rd_o && !lb_wr_o);

  // R4: line-buffer port never reads and writes at once
  a_r4_port_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lb_rd_o && lb_wr_o));
endmodule

bind cursor_ovl cursor_ovl_chk #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .img_rd_o(img_rd_o), .lb_rd_o(lb_rd_o),
  .lb_wr_o(lb_wr_o), .lb_addr_o(lb_addr_o), .done_o(done_o)
);

// File: tb/sim_cursor_ovl.sv
`timescale 1ns/1ps
module sim_cursor_ovl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_ni, frame_start, alt_mode, line_start;
  logic [9:0]   cur_x, cur_y, line_y;
  logic         img_rd, lb_rd, lb_wr, done;
  logic [4:0]   img_row;
  logic [127:0] img_q;
  logic [6:0]   lb_addr;
  logic [31:0]  lb_wdata, rdq;
  logic [31:0]  lbm [80];
  logic         reload;
  int total = 0, bad = 0;

  cursor_ovl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frame_start_i(frame_start), .cur_x_i(cur_x),
    .cur_y_i(cur_y), .alt_mode_i(alt_mode), .line_start_i(line_start), .line_y_i(line_y),
    .img_rd_o(img_rd), .img_row_o(img_row), .img_data_i(img_q), .lb_rd_o(lb_rd),
    .lb_wr_o(lb_wr), .lb_addr_o(lb_addr), .lb_wdata_o(lb_wdata), .lb_rdata_i(rdq),
    .done_o(done)
  );

  function automatic logic [3:0] img_px(int r, int j);
    return 4'((r * 5 + j * 3 + 1) % 16);
  endfunction

  function automatic logic [127:0] img_line(int r);
    logic [127:0] v;
    for (int j = 0; j < 32; j++) v[4*j +: 4] = img_px(r, j);
    return v;
  endfunction

  function automatic logic [31:0] base_w(int w);
    return 32'h9E37_79B9 ^ (32'(w) * 32'h0101_0101);
  endfunction

  function automatic logic [31:0] exp_w(int w, int cx, int cy, int ly, bit alt);
    logic [31:0] v = base_w(w);
    int dy = (((ly - cy) % 1024) + 1024) % 1024;
    for (int n = 0; n < 8; n++) begin
      int j = w * 8 + n - cx;
      if (dy < 32 && j >= 0 && j < 32) begin
        logic [3:0] c = img_px(dy, j);
        if (alt ? (c == 4'h0) : (c != 4'h0)) v[4*n +: 4] = c;
      end
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (reload) begin
      for (int w = 0; w < 80; w++) lbm[w] <= base_w(w);
    end else if (lb_wr && lb_addr < 7'd80) lbm[lb_addr] <= lb_wdata;
    if (lb_rd) rdq <= (lb_addr < 7'd80) ? lbm[lb_addr] : 32'h0;
    if (img_rd) img_q <= img_line(int'(img_row));
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic set_frame(int cx, int cy, bit alt);
    @(negedge clk);
    cur_x = 10'(cx); cur_y = 10'(cy); alt_mode = alt; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic do_reload();
    @(negedge clk); reload = 1'b1;
    @(negedge clk); reload = 1'b0;
  endtask

  task automatic run_line(int ly, output int nwr, output int oob, output bit seen, output bit quiet);
    @(negedge clk);
    line_start = 1'b1; line_y = 10'(ly);
    nwr = 0; oob = 0; seen = 1'b0;
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge clk);
      if (i == 0) line_start = 1'b0;
      if (lb_wr) begin nwr++; if (lb_addr >= 7'd80) oob++; end
      if (done) seen = 1'b1;
    end
    @(negedge clk);
    quiet = !done;
  endtask

  task automatic cmp_line(int cx, int cy, int ly, bit alt, string req);
    int mism = 0;
    logic [31:0] fa = '0, fe = '0;
    for (int w = 0; w < 80; w++) begin
      logic [31:0] e = exp_w(w, cx, cy, ly, alt);
      if (lbm[w] !== e) begin
        if (mism == 0) begin fa = lbm[w]; fe = e; end
        mism++;
      end
    end
    chk(mism == 0, req, "line contents", fa, fe);
  endtask

  // cx, cy, ly, alt, expected writes
  localparam int NV = 11;
  localparam int VEC [NV][5] = '{
    '{0,   0,    0,   0, 4},
    '{13,  100,  105, 0, 5},
    '{608, 10,   41,  0, 4},
    '{620, 10,   20,  0, 3},
    '{637, 5,    5,   1, 1},
    '{700, 5,    5,   0, 0},
    '{200, 50,   49,  0, 0},
    '{200, 50,   82,  0, 0},
    '{64,  300,  310, 1, 4},
    '{5,   479,  479, 1, 5},
    '{300, 1020, 3,   0, 5}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nwr, oob;
    bit seen, quiet;
    rst_ni = 1'b0; frame_start = 1'b0; alt_mode = 1'b0; line_start = 1'b0;
    cur_x = '0; cur_y = '0; line_y = '0; reload = 1'b0;
    repeat (3) @(negedge clk);
    // R9: strobes low in reset
    chk({img_rd, lb_rd, lb_wr, done} == 4'b0, "R9", "strobes in reset",
        32'({img_rd, lb_rd, lb_wr, done}), 32'h0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      set_frame(VEC[v][0], VEC[v][1], VEC[v][3] != 0);
      do_reload();
      run_line(VEC[v][2], nwr, oob, seen, quiet);
      chk(seen, "R8", "done seen", 32'(seen), 32'h1);
      chk(quiet, "R8", "done one cycle", 32'(quiet), 32'h1);
      chk(nwr == VEC[v][4], "R4/R5/R6", "write count", 32'(nwr), 32'(VEC[v][4]));
      chk(oob == 0, "R5", "out of line writes", 32'(oob), 32'h0);
      cmp_line(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3] != 0,
               (VEC[v][3] != 0) ? "R3" : "R1/R2");
    end

    // R7: inputs changed without frame_start are ignored
    set_frame(40, 0, 1'b0);
    @(negedge clk);
    cur_x = 10'd0; cur_y = 10'd200; alt_mode = 1'b1;
    do_reload();
    run_line(3, nwr, oob, seen, quiet);
    chk(nwr == 4, "R7", "write count with stale inputs", 32'(nwr), 32'h4);
    cmp_line(40, 0, 3, 1'b0, "R7");

    // R7: new values take effect after frame_start
    set_frame(0, 200, 1'b1);
    do_reload();
    run_line(3, nwr, oob, seen, quiet);
    chk(nwr == 0 && seen, "R7", "uncovered after new frame", 32'(nwr), 32'h0);
    cmp_line(0, 200, 3, 1'b1, "R7");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule